// File: doc/BRIEF.md
# Branch Target Buffer Predictor with Static Backstop

This block predicts the outcome of branches in the front end. The fetch stage presents each branch with its linear address and its decode information: whether it is conditional, whether its target is PC-relative, and the decoded PC-relative target. The block looks up a set-associative, tagged target buffer. Each entry holds a 2-bit saturating history counter and the last taken target. On a hit, the counter decides the prediction. On a miss, a fixed static rule decides it.

A taken prediction raises a redirect to the fetch address register, carrying the target, and at the same time raises a flush of the younger work fetched behind the branch. The execution stage reports resolved branches on a separate port. A report that hits trains the counter of that entry. A taken report that misses allocates a new entry. Replacement picks the lowest invalid way first and otherwise the least recently used way.

Top module: `bp_predictor`

## Requirements
- R1: The entry is selected by branch address bits [5:2] (the set) and [31:6] (the tag). `pred_valid_o` and `btb_hit_o` report a lookup exactly one cycle after `lookup_valid_i`. Both are low in every other cycle.
- R2: A hit whose counter is 2 or 3 raises `pred_taken_o`, `redirect_o` and `flush_o`, with `redirect_pc_o` set to the stored target.
- R3: A hit whose counter is 0 or 1 predicts not taken. `redirect_o` and `flush_o` stay low, so fetch continues sequentially.
- R4: Redirect and flush appear only in the cycle after a lookup, and they are always raised together.
- R5: On a miss, an unconditional branch with a PC-relative target (`lookup_cond_i`=0, `lookup_rel_i`=1) is predicted taken, and `redirect_pc_o` is set to `lookup_target_i`.
- R6: On a miss, a conditional PC-relative branch is predicted taken only if its target is strictly below its own address. A forward target or an equal target is predicted not taken. Any branch with `lookup_rel_i`=0 is predicted not taken.
- R7: A resolution that hits moves the counter up by one on taken and down by one on not taken, saturating at 3 and 0. A taken resolution also replaces the stored target.
- R8: A resolution that misses allocates an entry only if the branch was taken. The new entry starts with counter 2 and the reported target. A not-taken miss leaves the buffer unchanged.
- R9: Allocation uses the lowest invalid way of the set if one exists, and otherwise the least recently used way. Every resolution that hits or allocates makes its way the most recently used.
- R10: After reset, all entries are invalid and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | A branch is presented for prediction |
| lookup_pc_i | input | 32 | Linear address of the branch |
| lookup_cond_i | input | 1 | 1 = conditional, 0 = unconditional |
| lookup_rel_i | input | 1 | 1 = target is PC-relative and known from decode |
| lookup_target_i | input | 32 | Decoded PC-relative target |
| res_valid_i | input | 1 | A resolved branch is reported by execution |
| res_pc_i | input | 32 | Linear address of the resolved branch |
| res_taken_i | input | 1 | Resolved direction |
| res_target_i | input | 32 | Resolved target |
| pred_valid_o | output | 1 | A prediction result is present |
| btb_hit_o | output | 1 | The prediction came from a buffer hit |
| pred_taken_o | output | 1 | The branch is predicted taken |
| redirect_o | output | 1 | Load `redirect_pc_o` into the fetch address register |
| redirect_pc_o | output | 32 | Predicted target |
| flush_o | output | 1 | Discard work fetched behind the branch |

## Verification
Several properties are checked on every cycle:
- The per-set recency state always remains a permutation of the ages.
- Within a live entry, the counter never moves by more than one step.
- An entry becomes valid only after a taken resolution.
- A redirect never appears without a lookup in the cycle before.
- A static unconditional miss always redirects to its decoded target.

Only the bench scenarios can show the rest. They cover the exact counter trajectory through both saturation points and the replacement of the target. They show which way is evicted after a particular history of touches. They also show that a not-taken miss leaves every resident entry in place.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_ALLOC = 2'd2;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic ctr_says_taken(ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule #(
  parameter int ADDR_W = 32
) (
  input  logic              cond_i,
  input  logic              rel_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              taken_o
);
  // unconditional relative: taken; conditional relative: backward only
  assign taken_o = rel_i && (!cond_i || (target_i < pc_i));
endmodule

// File: rtl/bp_lru.sv
module bp_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set_i][w] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(w);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_perm
    logic [WAYS-1:0] seen;
    always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[age_q[s][w]] = 1'b1;
    end
    assert_lru_perm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni) &seen);
  end
endmodule

// File: rtl/bp_btb.sv
module bp_btb
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic              hit_o,
  output logic              hit_taken_o,
  output logic [ADDR_W-1:0] hit_target_o,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_target_i
);
  logic              vld_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  ctr_t              ctr_q [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q [SETS][WAYS];

  logic unused_low;
  assign unused_low = ^{lk_pc_i[OFF_W-1:0], res_pc_i[OFF_W-1:0]};

  logic [SET_W-1:0] lk_set, rs_set;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  assign lk_set = lk_pc_i[OFF_W +: SET_W];
  assign lk_tag = lk_pc_i[ADDR_W-1 -: TAG_W];
  assign rs_set = res_pc_i[OFF_W +: SET_W];
  assign rs_tag = res_pc_i[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit_o = 1'b0; hit_taken_o = 1'b0; hit_target_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        hit_o        = 1'b1;
        hit_taken_o  = ctr_says_taken(ctr_q[lk_set][w]);
        hit_target_o = tgt_q[lk_set][w];
      end
  end

  logic             rs_hit, rs_free;
  logic [WAY_W-1:0] rs_way, free_way, lru_way, alloc_way;

  always_comb begin
    rs_hit = 1'b0; rs_way = '0; rs_free = 1'b0; free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_q[rs_set][w]) begin rs_free = 1'b1; free_way = WAY_W'(w); end
    end
    for (int w = 0; w < WAYS; w++)
      if (vld_q[rs_set][w] && tag_q[rs_set][w] == rs_tag) begin
        rs_hit = 1'b1; rs_way = WAY_W'(w);
      end
  end

  assign alloc_way = rs_free ? free_way : lru_way;

  bp_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (res_valid_i && (rs_hit || res_taken_i)),
    .touch_set_i (rs_set),
    .touch_way_i (rs_hit ? rs_way : alloc_way),
    .query_set_i (rs_set),
    .victim_o    (lru_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld_q[s][w] <= 1'b0;
          tag_q[s][w] <= '0;
          ctr_q[s][w] <= '0;
          tgt_q[s][w] <= '0;
        end
    end else if (res_valid_i) begin
      if (rs_hit) begin
        ctr_q[rs_set][rs_way] <= ctr_step(ctr_q[rs_set][rs_way], res_taken_i);
        if (res_taken_i) tgt_q[rs_set][rs_way] <= res_target_i;
      end else if (res_taken_i) begin
        vld_q[rs_set][alloc_way] <= 1'b1;
        tag_q[rs_set][alloc_way] <= rs_tag;
        ctr_q[rs_set][alloc_way] <= CTR_ALLOC;
        tgt_q[rs_set][alloc_way] <= res_target_i;
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assert_ctr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(vld_q[s][w]) && $stable(tag_q[s][w])) |->
          (ctr_q[s][w] == $past(ctr_q[s][w]) ||
           ctr_q[s][w] == $past(ctr_q[s][w]) + 2'd1 ||
           ctr_q[s][w] == $past(ctr_q[s][w]) - 2'd1));
      assert_alloc_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vld_q[s][w]) |-> $past(res_valid_i && res_taken_i));
    end
  end
endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_pc_i,
  input  logic              lookup_cond_i,
  input  logic              lookup_rel_i,
  input  logic [ADDR_W-1:0] lookup_target_i,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_target_i,
  output logic              pred_valid_o,
  output logic              btb_hit_o,
  output logic              pred_taken_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              flush_o
);
  logic              hit, hit_taken, st_taken;
  logic [ADDR_W-1:0] hit_target;

  bp_btb #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .OFF_W(OFF_W)) u_btb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_pc_i      (lookup_pc_i),
    .hit_o        (hit),
    .hit_taken_o  (hit_taken),
    .hit_target_o (hit_target),
    .res_valid_i  (res_valid_i),
    .res_pc_i     (res_pc_i),
    .res_taken_i  (res_taken_i),
    .res_target_i (res_target_i)
  );

  bp_static_rule #(.ADDR_W(ADDR_W)) u_static (
    .cond_i   (lookup_cond_i),
    .rel_i    (lookup_rel_i),
    .pc_i     (lookup_pc_i),
    .target_i (lookup_target_i),
    .taken_o  (st_taken)
  );

  logic              take_d;
  logic [ADDR_W-1:0] tgt_d;
  assign take_d = lookup_valid_i && (hit ? hit_taken : st_taken);
  assign tgt_d  = hit ? hit_target : lookup_target_i;

  logic              valid_q, hit_q, take_q;
  logic [ADDR_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0; hit_q <= 1'b0; take_q <= 1'b0; tgt_q <= '0;
    end else begin
      valid_q <= lookup_valid_i;
      hit_q   <= lookup_valid_i && hit;
      take_q  <= take_d;
      tgt_q   <= take_d ? tgt_d : '0;
    end
  end

  assign pred_valid_o  = valid_q;
  assign btb_hit_o     = hit_q;
  assign pred_taken_o  = take_q;
  assign redirect_o    = take_q;
  assign flush_o       = take_q;
  assign redirect_pc_o = tgt_q;

  assert_redirect_after_lookup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(lookup_valid_i));
  assert_static_uncond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lookup_valid_i && !hit && !lookup_cond_i && lookup_rel_i) |=>
      (redirect_o && redirect_pc_o == $past(lookup_target_i)));
endmodule

// File: tb/sim_bp_predictor.sv
`timescale 1ns/1ps
module sim_bp_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0, lookup_cond_i = 1'b0, lookup_rel_i = 1'b0;
  logic [31:0] lookup_pc_i = '0, lookup_target_i = '0;
  logic        res_valid_i = 1'b0, res_taken_i = 1'b0;
  logic [31:0] res_pc_i = '0, res_target_i = '0;
  logic        pred_valid_o, btb_hit_o, pred_taken_o, redirect_o, flush_o;
  logic [31:0] redirect_pc_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bp_predictor u0 (.*);

  typedef struct packed {
    logic        cond;
    logic        rel;
    logic [31:0] pc;
    logic [31:0] tgt;
    logic        exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 1'b1, 32'h2000_0014, 32'h2000_0100, 1'b0},
    '{1'b1, 1'b1, 32'h2000_0414, 32'h2000_0020, 1'b1},
    '{1'b0, 1'b1, 32'h2000_0814, 32'h2000_4000, 1'b1},
    '{1'b0, 1'b1, 32'h2000_0c14, 32'h2000_0000, 1'b1},
    '{1'b1, 1'b0, 32'h2000_1014, 32'h2000_0000, 1'b0},
    '{1'b0, 1'b0, 32'h2000_1414, 32'h2000_8000, 1'b0},
    '{1'b1, 1'b1, 32'h2000_1814, 32'h2000_1814, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] pc, logic cond, logic rel, logic [31:0] tgt);
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_pc_i = pc; lookup_cond_i = cond;
    lookup_rel_i = rel; lookup_target_i = tgt;
    @(negedge clk_i);
    lookup_valid_i = 1'b0;
  endtask

  task automatic resolve(logic [31:0] pc, logic taken, logic [31:0] tgt);
    @(negedge clk_i);
    res_valid_i = 1'b1; res_pc_i = pc; res_taken_i = taken; res_target_i = tgt;
    @(negedge clk_i);
    res_valid_i = 1'b0;
  endtask

  // hit lookup, forward conditional so a miss would be not taken
  task automatic expect_hit(string req, logic [31:0] pc, logic taken, logic [31:0] tgt);
    lookup(pc, 1'b1, 1'b1, pc + 32'h100);
    check({req, " hit"}, 32'(btb_hit_o), 32'd1);
    check({req, " taken"}, 32'(redirect_o), 32'(taken));
    check({req, " flush"}, 32'(flush_o), 32'(taken));
    if (taken) check({req, " target"}, redirect_pc_o, tgt);
  endtask

  task automatic expect_miss(string req, logic [31:0] pc);
    lookup(pc, 1'b1, 1'b1, pc + 32'h100);
    check({req, " miss"}, 32'(btb_hit_o), 32'd0);
    check({req, " no redirect"}, 32'(redirect_o), 32'd0);
  endtask

  localparam logic [31:0] PA = 32'h0001_0000;
  localparam logic [31:0] PB = PA + 32'h40;
  localparam logic [31:0] PC = PA + 32'h80;
  localparam logic [31:0] PD = PA + 32'hC0;
  localparam logic [31:0] PE = PA + 32'h100;
  localparam logic [31:0] PF = PA + 32'h140;
  localparam logic [31:0] PG = PA + 32'h180;

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 pred_valid", 32'(pred_valid_o), 32'd0);
    check("R10 redirect", 32'(redirect_o), 32'd0);
    check("R10 flush", 32'(flush_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // static rule table: R5, R6, R1
    foreach (VEC[i]) begin
      lookup(VEC[i].pc, VEC[i].cond, VEC[i].rel, VEC[i].tgt);
      check("R1 pred_valid", 32'(pred_valid_o), 32'd1);
      check("R1 miss", 32'(btb_hit_o), 32'd0);
      check(VEC[i].cond ? "R6 static taken" : "R5 static taken", 32'(redirect_o), 32'(VEC[i].exp));
      check("R4 flush with redirect", 32'(flush_o), 32'(VEC[i].exp));
      if (VEC[i].exp) check("R5 static target", redirect_pc_o, VEC[i].tgt);
    end

    // R8 not-taken miss does not allocate
    resolve(PA, 1'b0, 32'h0);
    check("R4 idle no redirect", 32'(redirect_o), 32'd0);
    check("R1 idle no valid", 32'(pred_valid_o), 32'd0);
    expect_miss("R8 nt no alloc", PA);

    // R8 allocate with counter 2, R2 taken hit
    resolve(PA, 1'b1, 32'h0000_5000);
    expect_hit("R8 alloc", PA, 1'b1, 32'h0000_5000);

    // R7 counter trajectory, R3 not-taken hit
    resolve(PA, 1'b0, 32'h0);
    expect_hit("R3 ctr1", PA, 1'b0, 32'h0);
    resolve(PA, 1'b0, 32'h0);
    resolve(PA, 1'b0, 32'h0);
    resolve(PA, 1'b1, 32'h0000_5000);
    expect_hit("R7 low saturate", PA, 1'b0, 32'h0);
    resolve(PA, 1'b1, 32'h0000_6000);
    expect_hit("R7 target update", PA, 1'b1, 32'h0000_6000);
    resolve(PA, 1'b1, 32'h0000_6000);
    resolve(PA, 1'b1, 32'h0000_6000);
    resolve(PA, 1'b1, 32'h0000_6000);
    resolve(PA, 1'b0, 32'h0);
    expect_hit("R7 high saturate", PA, 1'b1, 32'h0000_6000);
    resolve(PA, 1'b0, 32'h0);
    expect_hit("R7 back to 1", PA, 1'b0, 32'h0);

    // R9 fill the set through free ways
    resolve(PB, 1'b1, 32'h0000_B000);
    resolve(PC, 1'b1, 32'h0000_C000);
    resolve(PD, 1'b1, 32'h0000_D000);
    expect_hit("R9 free way keeps A", PA, 1'b0, 32'h0);
    expect_hit("R9 B resident", PB, 1'b1, 32'h0000_B000);
    // touches: A B C D, then A -> LRU is B
    resolve(PA, 1'b1, 32'h0000_6000);
    resolve(PE, 1'b1, 32'h0000_E000);
    expect_miss("R9 B evicted", PB);
    expect_hit("R9 C kept", PC, 1'b1, 32'h0000_C000);
    expect_hit("R9 E placed", PE, 1'b1, 32'h0000_E000);
    // lookups do not touch; order C D A E -> LRU is C
    resolve(PF, 1'b1, 32'h0000_F000);
    expect_miss("R9 C evicted", PC);
    expect_hit("R9 D kept", PD, 1'b1, 32'h0000_D000);
    // full set, not-taken miss must not evict D (LRU now)
    resolve(PG, 1'b0, 32'h0);
    expect_hit("R8 full nt no evict", PD, 1'b1, 32'h0000_D000);
    expect_miss("R8 G absent", PG);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule